// File: doc/BRIEF.md
# Guest System Mask Update Assist

This block accelerates the three privileged instructions that change the interrupt mask byte of a guest operating system: set-mask, AND-mask and OR-mask. The guest's program status word (PSW) is not held in the real processor state. It lives in memory, reached through a control block whose base address comes from an assist control register. On a `start` pulse the block walks that structure over a single word-wide memory port. It reads an optional activation word, the pointer to and contents of the guest's control register 0, the pointer to the guest PSW (whose sign bit flags a pending guest interrupt) and the guest PSW itself. For set-mask it also reads the operand byte. It then checks whether the change is safe. If so, it writes the new mask into the guest PSW and returns `accepted`. If not, it returns a decline, and the surrounding core then takes the ordinary privileged-operation trap.

For the AND and OR forms the previous mask byte is saved to the operand address before the PSW is committed. This save is a read-modify-write of the word that contains the byte, with byte lane 0 at bits 31..24. A failed memory access at any point ends the operation with a decline.

The FSM has these states: IDLE, GATE (activation word), VCRP (guest CR0 pointer), VCR0 (guest CR0), PSWP (PSW pointer), PSW (PSW word), OPND (operand byte, set-mask only), EVAL (safety rules), SAVE_RD and SAVE_WR (old-mask store, AND/OR only), PSW_WR (commit), ACCEPT and DECLINE. The transitions are:
- IDLE goes to DECLINE for the reserved code, to GATE when the activation bit is set, and to VCRP otherwise.
- GATE goes to VCRP or DECLINE.
- VCRP goes to VCR0. VCR0 goes to PSWP or DECLINE. PSWP goes to PSW.
- PSW goes to OPND for set-mask and to EVAL otherwise. OPND goes to EVAL.
- EVAL goes to PSW_WR (set-mask), to SAVE_RD (AND/OR) or to DECLINE.
- SAVE_RD goes to SAVE_WR. SAVE_WR goes to PSW_WR. PSW_WR goes to ACCEPT.
- Any faulting access goes to DECLINE. ACCEPT and DECLINE return to IDLE.

Top module: `gsm_assist`

## Requirements
- R1: Each operation ends with `done` high for exactly one cycle. `accepted` is 1 for success and 0 for a decline.
- R2: When `cr6` bit 24 is 1, the word at control-block byte offset 20 is read first. If its bit 23 is 0, the operation declines. When `cr6` bit 24 is 0, that word is not consulted.
- R3: The control block base is `cr6` bits ADDR_W-1..3 with three zero low bits. Offset 4 holds the guest CR0 pointer. If bit 30 of guest CR0 is 1, set-mask and OR-mask decline, while AND-mask proceeds.
- R4: Operation codes are 00 set, 01 AND and 10 OR. Set-mask takes its new byte from the operand word, in lane `opnd_addr[1:0]`, where lane 0 is bits 31..24. A fault on that read declines.
- R5: Set-mask in extended-control mode (guest PSW bit 19 = 1) declines under any of these conditions: the new byte has any bit of 0xB8 set; bit 0x40 or 0x04 changes; or an interrupt is pending and a bit of 0x03 turns on.
- R6: Set-mask in basic-control mode declines only if an interrupt is pending and some mask bit turns on.
- R7: OR-mask in extended-control mode declines if a bit of 0xFC would turn on, or if an interrupt is pending and a bit of 0x03 turns on.
- R8: OR-mask in basic-control mode declines if an interrupt is pending and some mask bit turns on.
- R9: AND-mask in extended-control mode declines unless the immediate has both 0x40 and 0x04 set. In basic-control mode AND-mask never declines on mask grounds.
- R10: On success the guest PSW bits 23..0 are kept. Bits 31..24 become the new byte (set), old AND immediate (AND) or old OR immediate (OR).
- R11: AND-mask and OR-mask store the old mask byte into its lane of the operand word, keeping the other three bytes, before the PSW write. If that store faults, the operation declines and the PSW is left untouched.
- R12: Code 11 declines without any memory access.
- R13: A memory request holds its address, direction and data until `mem_ack`. An acknowledge with `mem_err` declines the operation. A declined operation does not write the guest PSW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken in IDLE) |
| op | input | 2 | Operation code: 00 set, 01 AND, 10 OR, 11 reserved |
| imm | input | 8 | Immediate byte for AND/OR |
| opnd_addr | input | ADDR_W | Operand byte address |
| cr6 | input | 32 | Assist control register: base address and activation bit 24 |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access faulted (valid with mem_ack) |
| mem_rdata | input | 32 | Read data (valid with mem_ack) |
| done | output | 1 | One-cycle completion pulse |
| accepted | output | 1 | With done: 1 success, 0 decline |

## Verification
The assertions assume the following about the memory responder: it raises `mem_ack` only while `mem_req` is high, and for one cycle at a time; `mem_err` and `mem_rdata` have meaning only with `mem_ack`. The decline properties also assume that `start` is offered only while the block is idle. The bench memory model answers one cycle after each new request and lowers the acknowledge the next cycle. The bench pulses `start` only after the previous `done`, and faults are injected only as flagged errors on the operand read or the save write.

// File: rtl/gsm_pkg.sv
package gsm_pkg;

    typedef enum logic [1:0] {
        OP_SET  = 2'b00,
        OP_AND  = 2'b01,
        OP_OR   = 2'b10,
        OP_RSVD = 2'b11
    } gsm_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GATE,
        S_VCRP,
        S_VCR0,
        S_PSWP,
        S_PSW,
        S_OPND,
        S_EVAL,
        S_SAVE_RD,
        S_SAVE_WR,
        S_PSW_WR,
        S_ACCEPT,
        S_DECLINE
    } gsm_state_e;

    localparam int WORD_BYTES   = 4;
    localparam int WORD_W       = 8 * WORD_BYTES;

    // control block word indices
    localparam int CB_VCR_WORD  = 1;
    localparam int CB_PSW_WORD  = 2;
    localparam int CB_GATE_WORD = 5;

    // bit positions
    localparam int CR6_GATE_BIT = 24;
    localparam int GATE_OK_BIT  = 23;
    localparam int VCR0_BLK_BIT = 30;
    localparam int PEND_BIT     = 31;
    localparam int EC_BIT       = 19;

    // mask byte groups
    localparam logic [7:0] SET_EC_RSVD  = 8'hB8;
    localparam logic [7:0] DAT_PER      = 8'h44;
    localparam logic [7:0] OR_EC_LOCKED = 8'hFC;
    localparam logic [7:0] IRQ_GROUP    = 8'h03;

endpackage

// File: rtl/gsm_mask_rules.sv
module gsm_mask_rules
    import gsm_pkg::*;
(
    input  gsm_op_e    op,
    input  logic       ec_mode,
    input  logic       pending,
    input  logic [7:0] old_mask,
    input  logic [7:0] src_byte,
    output logic [7:0] new_mask,
    output logic       ok
);

    logic [7:0] turned;

    always_comb begin
        new_mask = old_mask;
        turned   = '0;
        ok       = 1'b0;
        unique case (op)
            OP_SET: begin
                new_mask = src_byte;
                turned   = old_mask ^ src_byte;
                if (ec_mode)
                    ok = ~|(src_byte & SET_EC_RSVD)
                      && ~|(turned & DAT_PER)
                      && !(pending && |(turned & src_byte & IRQ_GROUP));
                else
                    ok = !(pending && |(turned & src_byte));
            end
            OP_AND: begin
                new_mask = old_mask & src_byte;
                ok       = ec_mode ? ((src_byte & DAT_PER) == DAT_PER) : 1'b1;
            end
            OP_OR: begin
                new_mask = old_mask | src_byte;
                turned   = src_byte & ~old_mask;
                if (ec_mode)
                    ok = ~|(turned & OR_EC_LOCKED)
                      && !(pending && |(turned & IRQ_GROUP));
                else
                    ok = !(pending && |turned);
            end
            default: begin
                new_mask = old_mask;
                ok       = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/gsm_byte_lane.sv
module gsm_byte_lane #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0]         pick_word,
    input  logic [8*LANES-1:0]         merge_word,
    input  logic [$clog2(LANES)-1:0]   lane,
    input  logic [7:0]                 ins_byte,
    output logic [7:0]                 picked,
    output logic [8*LANES-1:0]         merged
);

    localparam int LANE_W = $clog2(LANES);

    always_comb begin
        picked = '0;
        merged = merge_word;
        for (int i = 0; i < LANES; i++) begin
            if (lane == LANE_W'(i)) begin
                picked                      = pick_word[8*(LANES-1-i) +: 8];
                merged[8*(LANES-1-i) +: 8]  = ins_byte;
            end
        end
    end

endmodule

// File: rtl/gsm_assist.sv
module gsm_assist
    import gsm_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [7:0]        imm,
    input  logic [ADDR_W-1:0] opnd_addr,
    input  logic [31:0]       cr6,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic              accepted
);

    localparam int LANE_W = $clog2(WORD_BYTES);
    localparam logic [ADDR_W-1:0] OFF_VCR  = ADDR_W'(WORD_BYTES * CB_VCR_WORD);
    localparam logic [ADDR_W-1:0] OFF_PSW  = ADDR_W'(WORD_BYTES * CB_PSW_WORD);
    localparam logic [ADDR_W-1:0] OFF_GATE = ADDR_W'(WORD_BYTES * CB_GATE_WORD);

    gsm_state_e        state, state_nx;
    gsm_op_e           op_q;
    logic [7:0]        imm_q;
    logic [ADDR_W-1:0] oaddr_q;
    logic [ADDR_W-1:0] cb_q;
    logic [ADDR_W-1:0] vcr_ptr_q;
    logic [ADDR_W-1:0] psw_ptr_q;
    logic              pend_q;
    logic [31:0]       psw_q;
    logic [7:0]        obyte_q;
    logic [31:0]       save_q;
    logic [7:0]        newmask_q;

    logic [7:0]        rule_mask;
    logic              rule_ok;
    logic [7:0]        lane_byte;
    logic [31:0]       lane_merged;
    logic              fault;

    logic unused_bits;
    assign unused_bits = ^{cr6, vcr_ptr_q[LANE_W-1:0], psw_ptr_q[LANE_W-1:0]};

    assign fault = mem_ack && mem_err;

    gsm_mask_rules u_rules (
        .op       (op_q),
        .ec_mode  (psw_q[EC_BIT]),
        .pending  (pend_q),
        .old_mask (psw_q[31:24]),
        .src_byte ((op_q == OP_SET) ? obyte_q : imm_q),
        .new_mask (rule_mask),
        .ok       (rule_ok)
    );

    gsm_byte_lane #(.LANES(WORD_BYTES)) u_lane (
        .pick_word  (mem_rdata),
        .merge_word (save_q),
        .lane       (oaddr_q[LANE_W-1:0]),
        .ins_byte   (psw_q[31:24]),
        .picked     (lane_byte),
        .merged     (lane_merged)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) begin
                if (gsm_op_e'(op) == OP_RSVD)   state_nx = S_DECLINE;
                else if (cr6[CR6_GATE_BIT])     state_nx = S_GATE;
                else                            state_nx = S_VCRP;
            end
            S_GATE: if (mem_ack)
                state_nx = (mem_err || !mem_rdata[GATE_OK_BIT]) ? S_DECLINE : S_VCRP;
            S_VCRP: if (mem_ack)
                state_nx = mem_err ? S_DECLINE : S_VCR0;
            S_VCR0: if (mem_ack)
                state_nx = (mem_err || (op_q != OP_AND && mem_rdata[VCR0_BLK_BIT]))
                           ? S_DECLINE : S_PSWP;
            S_PSWP: if (mem_ack)
                state_nx = mem_err ? S_DECLINE : S_PSW;
            S_PSW: if (mem_ack)
                state_nx = mem_err ? S_DECLINE : ((op_q == OP_SET) ? S_OPND : S_EVAL);
            S_OPND: if (mem_ack)
                state_nx = mem_err ? S_DECLINE : S_EVAL;
            S_EVAL:
                state_nx = !rule_ok ? S_DECLINE : ((op_q == OP_SET) ? S_PSW_WR : S_SAVE_RD);
            S_SAVE_RD: if (mem_ack)
                state_nx = mem_err ? S_DECLINE : S_SAVE_WR;
            S_SAVE_WR: if (mem_ack)
                state_nx = mem_err ? S_DECLINE : S_PSW_WR;
            S_PSW_WR: if (mem_ack)
                state_nx = mem_err ? S_DECLINE : S_ACCEPT;
            S_ACCEPT:  state_nx = S_IDLE;
            S_DECLINE: state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_SET;
            imm_q     <= '0;
            oaddr_q   <= '0;
            cb_q      <= '0;
            vcr_ptr_q <= '0;
            psw_ptr_q <= '0;
            pend_q    <= 1'b0;
            psw_q     <= '0;
            obyte_q   <= '0;
            save_q    <= '0;
            newmask_q <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                op_q    <= gsm_op_e'(op);
                imm_q   <= imm;
                oaddr_q <= opnd_addr;
                cb_q    <= {cr6[ADDR_W-1:3], 3'b000};
            end
            if (mem_ack && !mem_err) begin
                if (state == S_VCRP)    vcr_ptr_q <= mem_rdata[ADDR_W-1:0];
                if (state == S_PSWP) begin
                    psw_ptr_q <= mem_rdata[ADDR_W-1:0];
                    pend_q    <= mem_rdata[PEND_BIT];
                end
                if (state == S_PSW)     psw_q   <= mem_rdata;
                if (state == S_OPND)    obyte_q <= lane_byte;
                if (state == S_SAVE_RD) save_q  <= mem_rdata;
            end
            if (state == S_EVAL) newmask_q <= rule_mask;
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        accepted  = 1'b0;
        unique case (state)
            S_GATE: begin
                mem_req  = 1'b1;
                mem_addr = cb_q + OFF_GATE;
            end
            S_VCRP: begin
                mem_req  = 1'b1;
                mem_addr = cb_q + OFF_VCR;
            end
            S_VCR0: begin
                mem_req  = 1'b1;
                mem_addr = {vcr_ptr_q[ADDR_W-1:LANE_W], LANE_W'(0)};
            end
            S_PSWP: begin
                mem_req  = 1'b1;
                mem_addr = cb_q + OFF_PSW;
            end
            S_PSW: begin
                mem_req  = 1'b1;
                mem_addr = {psw_ptr_q[ADDR_W-1:LANE_W], LANE_W'(0)};
            end
            S_OPND, S_SAVE_RD: begin
                mem_req  = 1'b1;
                mem_addr = {oaddr_q[ADDR_W-1:LANE_W], LANE_W'(0)};
            end
            S_SAVE_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {oaddr_q[ADDR_W-1:LANE_W], LANE_W'(0)};
                mem_wdata = lane_merged;
            end
            S_PSW_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {psw_ptr_q[ADDR_W-1:LANE_W], LANE_W'(0)};
                mem_wdata = {newmask_q, psw_q[23:0]};
            end
            S_ACCEPT: begin
                done     = 1'b1;
                accepted = 1'b1;
            end
            S_DECLINE: done = 1'b1;
            default: ;
        endcase
    end

    // assertions
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R13
    AST_ERR_DECLINE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack && mem_err |=> done && !accepted); // R13
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1
    AST_RSVD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_IDLE && start && op == 2'b11 |=> done && !accepted && !mem_req); // R12
    AST_GATE_DECLINE: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_GATE && mem_ack && !mem_rdata[GATE_OK_BIT] |=> done && !accepted); // R2
    AST_VCR0_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_VCR0 && mem_ack && mem_rdata[VCR0_BLK_BIT] && op_q != OP_AND |=> done && !accepted); // R3
    AST_SET_EC_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_EVAL && op_q == OP_SET && psw_q[EC_BIT] && |(obyte_q & SET_EC_RSVD) |=> done && !accepted); // R5

endmodule

// File: tb/tb_gsm_assist.sv
module tb_gsm_assist;
    localparam int ADDR_W = 24;
    localparam int NVEC   = 24;
    localparam logic [31:0] BG = 32'hA1B2C3D4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        op = 2'b00;
    logic [7:0]        imm = 8'h00;
    logic [ADDR_W-1:0] opnd_addr = '0;
    logic [31:0]       cr6 = '0;
    logic              mem_req, mem_we, mem_ack, mem_err;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata, mem_rdata;
    logic              done, accepted;

    int n_chk = 0;
    int n_bad = 0;
    int acc_cnt = 0;
    int fault_mode = 0;

    logic [31:0] mem [0:1023];

    always #4 clk = ~clk;

    gsm_assist #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .imm(imm),
        .opnd_addr(opnd_addr), .cr6(cr6),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .done(done), .accepted(accepted)
    );

    // memory responder
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_err   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            logic hit;
            hit = (mem_addr[11:2] == 10'h100) &&
                  ((fault_mode == 1 && !mem_we) || (fault_mode == 2 && mem_we));
            acc_cnt   <= acc_cnt + 1;
            mem_ack   <= 1'b1;
            mem_err   <= hit;
            mem_rdata <= mem[mem_addr[11:2]];
            if (mem_we && !hit) mem[mem_addr[11:2]] <= mem_wdata;
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
    end

    // {op, gate, acf23, vcr30, pend, ec, old, byte, lane, fault, expect_accept}
    localparam logic [27:0] VEC [NVEC] = '{
        {2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h05,8'h07,2'd0,2'd0,1'b1}, // R5 EC set accepted
        {2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h05,8'h0D,2'd1,2'd0,1'b0}, // R5 reserved bit 0x08
        {2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h05,8'h01,2'd2,2'd0,1'b0}, // R5 DAT change
        {2'd0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h04,8'h06,2'd3,2'd0,1'b0}, // R5 pending, irq on
        {2'd0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h07,8'h05,2'd0,2'd0,1'b1}, // R5 pending, irq off
        {2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h80,8'hC0,2'd1,2'd0,1'b0}, // R6 pending, bit on
        {2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h80,8'hFF,2'd2,2'd0,1'b1}, // R6 no pending
        {2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,8'hFF,8'h0F,2'd3,2'd0,1'b1}, // R6 pending, bits off
        {2'd0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h05,8'h07,2'd0,2'd0,1'b0}, // R3 set blocked
        {2'd1,1'b0,1'b0,1'b1,1'b0,1'b1,8'h47,8'hFC,2'd1,2'd0,1'b1}, // R3 R9 AND not blocked
        {2'd1,1'b0,1'b0,1'b0,1'b0,1'b1,8'h47,8'hBF,2'd1,2'd0,1'b0}, // R9 AND drops PER
        {2'd1,1'b0,1'b0,1'b0,1'b1,1'b0,8'hFF,8'h00,2'd3,2'd0,1'b1}, // R9 AND basic mode
        {2'd2,1'b0,1'b0,1'b0,1'b0,1'b1,8'h04,8'h08,2'd0,2'd0,1'b0}, // R7 locked bit on
        {2'd2,1'b0,1'b0,1'b0,1'b0,1'b1,8'h04,8'h03,2'd2,2'd0,1'b1}, // R7 accepted
        {2'd2,1'b0,1'b0,1'b0,1'b1,1'b1,8'h04,8'h01,2'd1,2'd0,1'b0}, // R7 pending, irq on
        {2'd2,1'b0,1'b0,1'b0,1'b1,1'b1,8'h07,8'h03,2'd0,2'd0,1'b1}, // R7 nothing turns on
        {2'd2,1'b0,1'b0,1'b0,1'b1,1'b0,8'h80,8'h01,2'd3,2'd0,1'b0}, // R8 pending, bit on
        {2'd2,1'b0,1'b0,1'b0,1'b1,1'b0,8'h81,8'h01,2'd0,2'd0,1'b1}, // R8 already on
        {2'd2,1'b0,1'b0,1'b1,1'b0,1'b1,8'h04,8'h03,2'd2,2'd0,1'b0}, // R3 OR blocked
        {2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,8'h05,8'h07,2'd0,2'd0,1'b0}, // R2 gate closed
        {2'd0,1'b1,1'b1,1'b0,1'b0,1'b1,8'h05,8'h07,2'd3,2'd0,1'b1}, // R2 gate open
        {2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h05,8'h07,2'd1,2'd1,1'b0}, // R4 R13 operand fault
        {2'd2,1'b0,1'b0,1'b0,1'b0,1'b1,8'h04,8'h03,2'd2,2'd2,1'b0}, // R11 save fault
        {2'd3,1'b0,1'b0,1'b0,1'b0,1'b1,8'h05,8'h07,2'd0,2'd0,1'b0}  // R12 reserved code
    };

    function automatic logic [31:0] put_lane(logic [31:0] w, logic [1:0] l, logic [7:0] b);
        logic [31:0] r;
        r = w;
        r[8*(3-l) +: 8] = b;
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic run_vec(int i);
        logic [27:0] v;
        logic [1:0]  vop, lane;
        logic        g, a, vc, p, ec, ex_acc;
        logic [7:0]  old, b, nm;
        logic [31:0] psw0, opw0, ex_psw, ex_opw;
        int          cnt0, t;
        v = VEC[i];
        {vop, g, a, vc, p, ec, old, b, lane} = v[27:3];
        ex_acc = v[0];
        psw0 = {old, ec ? 24'h080ABC : 24'h701234};
        opw0 = (vop == 2'd0) ? put_lane(BG, lane, b) : BG;
        mem[10'h041] = 32'h0000_0200;
        mem[10'h042] = {p, 31'h0000_0300};
        mem[10'h045] = a ? 32'h0080_0000 : 32'h0;
        mem[10'h080] = vc ? 32'h4000_0000 : 32'h0;
        mem[10'h0C0] = psw0;
        mem[10'h100] = opw0;
        fault_mode = int'(v[2:1]);
        case (vop)
            2'd0:    nm = b;
            2'd1:    nm = old & b;
            default: nm = old | b;
        endcase
        ex_psw = ex_acc ? {nm, psw0[23:0]} : psw0;
        ex_opw = (ex_acc && vop != 2'd0) ? put_lane(BG, lane, old) : opw0;
        cnt0 = acc_cnt;
        @(negedge clk);
        op = vop; imm = b; opnd_addr = ADDR_W'(32'h400) + ADDR_W'(lane);
        cr6 = g ? 32'h0100_0100 : 32'h0000_0100;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 200) begin
            @(negedge clk);
            t++;
        end
        check($sformatf("R1 accepted vec%0d", i), {31'b0, accepted}, {31'b0, ex_acc});
        @(negedge clk);
        check($sformatf("R1 done pulse vec%0d", i), {31'b0, done}, 32'h0);
        check($sformatf("R10 guest psw vec%0d", i), mem[10'h0C0], ex_psw);
        check($sformatf("R11 operand word vec%0d", i), mem[10'h100], ex_opw);
        if (vop == 2'd3)
            check("R12 memory accesses", 32'(acc_cnt - cnt0), 32'h0);
        fault_mode = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 1024; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        check("R1 reset done", {31'b0, done}, 32'h0);
        check("R13 reset request", {31'b0, mem_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) run_vec(i);
        // directed: back-to-back set then AND on same state (R10 R11)
        run_vec(6);
        run_vec(9);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule